// File: doc/BRIEF.md
# Interrupt Flag and Enable Controller

This block holds the interrupt flags and enables of a small 8-bit microcontroller. It watches three event sources: a one-cycle overflow strobe from an 8-bit timer, an external interrupt pin whose active edge is selectable, and three general-purpose input pins that are monitored for a change. Every source latches its own flag in an 8-bit control register, whether or not that source is enabled. Software reads and writes the whole register.

From that register the block drives one interrupt request to the core. The global enable bit is cleared when the core takes an interrupt and set again by a return-from-interrupt pulse. While the core is asleep, an external edge raises a wake-up request. This happens only if the external enable was set when sleep began. A second output tells the core whether to branch to the interrupt vector after waking, which the global enable alone decides. Saving the return address and any context belongs to the core and to software.

Control register layout: bit 7 global enable (GE), bit 6 plain storage, bit 5 timer enable (TE), bit 4 external enable (XE), bit 3 change enable (CE), bit 2 timer flag (TF), bit 1 external flag (XF), bit 0 change flag (CF).

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, and `irq_req_o`, `wake_o` and `wake_vector_o` are low.
- R2: A high `tmr_ovf_i` sets TF (bit 2) at the next clock edge, whatever TE (bit 5) holds. TF then stays set until software writes a 0 to it.
- R3: XF (bit 1) is set by a rising edge on `ext_pin_i` when `edge_rise_i` is 1, and by a falling edge when it is 0. An edge of the other polarity leaves XF unchanged. The flag becomes visible on the third clock edge after the pin changes.
- R4: CF (bit 0) is set when any of the three synchronized `chg_pins_i` differs from a reference latch, whatever CE (bit 3) holds. A `port_rd_i` pulse loads the reference latch with the synchronized pin value. After a reset, the reference latch holds 0.
- R5: `irq_req_o` equals GE AND ((TE AND TF) OR (XE AND XF) OR (CE AND CF)).
- R6: An `irq_take_i` pulse clears GE at the next edge, and a `retfie_i` pulse sets it. When both pulses arrive in the same cycle, GE is set.
- R7: If a hardware event sets a flag in the same cycle as a software write that clears that flag, the flag ends set.
- R8: `wake_o` is high while `sleep_i` has been high for at least one full cycle, XF is set, and XE was 1 in the first cycle of sleep. A change to XE during sleep does not affect `wake_o`.
- R9: `wake_vector_o` is high exactly when `wake_o` is high and GE is set.
- R10: A software write loads all eight bits from `ctl_wdata_i` at the next edge, bit 6 included. `ctl_rdata_o` shows the register at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_ovf_i | input | 1 | Timer rollover strobe, one cycle |
| ext_pin_i | input | 1 | External interrupt pin, asynchronous |
| edge_rise_i | input | 1 | 1 selects the rising edge on the external pin, 0 selects the falling edge |
| chg_pins_i | input | 3 | Monitored input pins, asynchronous |
| port_rd_i | input | 1 | Software port read; reloads the change reference |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 8 | Control register write data |
| ctl_rdata_o | output | 8 | Control register contents |
| irq_take_i | input | 1 | Core is taking an interrupt |
| retfie_i | input | 1 | Return-from-interrupt pulse |
| sleep_i | input | 1 | Core is in sleep |
| irq_req_o | output | 1 | Interrupt request to the core |
| wake_o | output | 1 | Wake-up request |
| wake_vector_o | output | 1 | On wake-up, branch to the vector |

## Verification
Write data, the timer strobe, the take pulse and the return pulse all land in the register one edge after they are driven. The request and both wake outputs follow the register in the same cycle. A pin change passes two synchronizer flops and then the flag register, so its flag appears on the third edge. The bench drives every input on the falling edge and samples one falling edge after the expected update edge. For pin events it also samples one cycle early, to confirm that the flag has not yet appeared.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int CTL_W  = 8;
  localparam int B_GE   = 7;
  localparam int B_SPR  = 6;
  localparam int B_TE   = 5;
  localparam int B_XE   = 4;
  localparam int B_CE   = 3;
  localparam int B_TF   = 2;
  localparam int B_XF   = 1;
  localparam int B_CF   = 0;

  // Edge match for the selected polarity
  function automatic logic edge_match(input logic prev, input logic cur, input logic rise_sel);
    return rise_sel ? (!prev && cur) : (prev && !cur);
  endfunction

  // Request term: global enable gating the enabled flags
  function automatic logic req_calc(input logic [CTL_W-1:0] r);
    logic any;
    any = (r[B_TE] & r[B_TF]) | (r[B_XE] & r[B_XF]) | (r[B_CE] & r[B_CF]);
    return r[B_GE] & any;
  endfunction
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/irqc_edge.sv
module irqc_edge
  import irqc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  input  logic rise_sel_i,
  output logic hit_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sig_i;
  end

  assign hit_o = edge_match(prev_q, sig_i, rise_sel_i);
endmodule

// File: rtl/irqc_change.sv
module irqc_change #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sig_i,
  input  logic         load_i,
  output logic         diff_o
);
  logic [W-1:0] ref_q;
  logic [W-1:0] mism;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ref_q <= '0;
    else if (load_i) ref_q <= sig_i;
  end

  for (genvar g = 0; g < W; g++) begin : g_cmp
    assign mism[g] = sig_i[g] ^ ref_q[g];
  end

  assign diff_o = |mism;
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irqc_pkg::*;
#(
  parameter int CHG_W     = 3,
  parameter int SYNC_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tmr_ovf_i,
  input  logic             ext_pin_i,
  input  logic             edge_rise_i,
  input  logic [CHG_W-1:0] chg_pins_i,
  input  logic             port_rd_i,
  input  logic             ctl_we_i,
  input  logic [CTL_W-1:0] ctl_wdata_i,
  output logic [CTL_W-1:0] ctl_rdata_o,
  input  logic             irq_take_i,
  input  logic             retfie_i,
  input  logic             sleep_i,
  output logic             irq_req_o,
  output logic             wake_o,
  output logic             wake_vector_o
);
  localparam int SYNC_W = CHG_W + 1;

  logic [SYNC_W-1:0] raw_pins;
  logic [SYNC_W-1:0] sync_pins;
  logic              ext_s;
  logic [CHG_W-1:0]  chg_s;
  logic              ext_hit;
  logic              chg_hit;
  logic [CTL_W-1:0]  ctl_q;
  logic [CTL_W-1:0]  ctl_d;
  logic              sleep_q;
  logic              xe_snap_q;
  logic              sleep_entry;

  assign raw_pins = {ext_pin_i, chg_pins_i};

  irqc_sync #(.W(SYNC_W), .STAGES(SYNC_DEPTH)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw_pins),
    .q_o   (sync_pins)
  );

  assign ext_s = sync_pins[SYNC_W-1];
  assign chg_s = sync_pins[CHG_W-1:0];

  irqc_edge u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .sig_i      (ext_s),
    .rise_sel_i (edge_rise_i),
    .hit_o      (ext_hit)
  );

  irqc_change #(.W(CHG_W)) u_chg (
    .clk    (clk),
    .rst_n  (rst_n),
    .sig_i  (chg_s),
    .load_i (port_rd_i),
    .diff_o (chg_hit)
  );

  // Next register value: write, then GE controls, then hardware sets on top
  always_comb begin
    ctl_d = ctl_q;
    if (ctl_we_i)   ctl_d = ctl_wdata_i;
    if (irq_take_i) ctl_d[B_GE] = 1'b0;
    if (retfie_i)   ctl_d[B_GE] = 1'b1;
    ctl_d[B_TF] = ctl_d[B_TF] | tmr_ovf_i;
    ctl_d[B_XF] = ctl_d[B_XF] | ext_hit;
    ctl_d[B_CF] = ctl_d[B_CF] | chg_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  // Sleep entry snapshot of the external enable
  assign sleep_entry = sleep_i && !sleep_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_q   <= 1'b0;
      xe_snap_q <= 1'b0;
    end else begin
      sleep_q <= sleep_i;
      if (sleep_entry) xe_snap_q <= ctl_q[B_XE];
    end
  end

  assign ctl_rdata_o   = ctl_q;
  assign irq_req_o     = req_calc(ctl_q);
  assign wake_o        = sleep_i && sleep_q && xe_snap_q && ctl_q[B_XF];
  assign wake_vector_o = wake_o && ctl_q[B_GE];
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       tmr_ovf_i,
  input logic       ctl_we_i,
  input logic [7:0] ctl_wdata_i,
  input logic [7:0] ctl_rdata_o,
  input logic       irq_take_i,
  input logic       retfie_i,
  input logic       sleep_i,
  input logic       irq_req_o,
  input logic       wake_o,
  input logic       wake_vector_o,
  input logic       ext_hit,
  input logic       chg_hit
);
  p_tmr_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ovf_i |=> ctl_rdata_o[2]);

  p_tmr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata_o[2] && !ctl_we_i) |=> ctl_rdata_o[2]);

  p_ext_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ext_hit |=> ctl_rdata_o[1]);

  p_chg_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    chg_hit |=> ctl_rdata_o[0]);

  p_no_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_rdata_o[7] |-> !irq_req_o);

  p_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_take_i && !retfie_i) |=> !ctl_rdata_o[7]);

  p_ret_r6: assert property (@(posedge clk) disable iff (!rst_n)
    retfie_i |=> ctl_rdata_o[7]);

  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we_i && !ctl_wdata_i[1] && ext_hit) |=> ctl_rdata_o[1]);

  p_wake_sleep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> (sleep_i && ctl_rdata_o[1]));

  p_vec_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_vector_o |-> (wake_o && ctl_rdata_o[7]));
endmodule

bind irq_flag_ctrl irqc_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .tmr_ovf_i     (tmr_ovf_i),
  .ctl_we_i      (ctl_we_i),
  .ctl_wdata_i   (ctl_wdata_i),
  .ctl_rdata_o   (ctl_rdata_o),
  .irq_take_i    (irq_take_i),
  .retfie_i      (retfie_i),
  .sleep_i       (sleep_i),
  .irq_req_o     (irq_req_o),
  .wake_o        (wake_o),
  .wake_vector_o (wake_vector_o),
  .ext_hit       (ext_hit),
  .chg_hit       (chg_hit)
);

// File: tb/irq_flag_ctrl_tb.sv
`timescale 1ns/1ps
module irq_flag_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tmr_ovf_i = 1'b0;
  logic       ext_pin_i = 1'b0;
  logic       edge_rise_i = 1'b1;
  logic [2:0] chg_pins_i = 3'b000;
  logic       port_rd_i = 1'b0;
  logic       ctl_we_i = 1'b0;
  logic [7:0] ctl_wdata_i = 8'h00;
  logic [7:0] ctl_rdata_o;
  logic       irq_take_i = 1'b0;
  logic       retfie_i = 1'b0;
  logic       sleep_i = 1'b0;
  logic       irq_req_o;
  logic       wake_o;
  logic       wake_vector_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_flag_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .tmr_ovf_i(tmr_ovf_i), .ext_pin_i(ext_pin_i),
    .edge_rise_i(edge_rise_i), .chg_pins_i(chg_pins_i), .port_rd_i(port_rd_i),
    .ctl_we_i(ctl_we_i), .ctl_wdata_i(ctl_wdata_i), .ctl_rdata_o(ctl_rdata_o),
    .irq_take_i(irq_take_i), .retfie_i(retfie_i), .sleep_i(sleep_i),
    .irq_req_o(irq_req_o), .wake_o(wake_o), .wake_vector_o(wake_vector_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Independent restatement of the request equation
  function automatic logic model_req(input logic [7:0] r);
    logic t, x, c;
    t = r[5] && r[2];
    x = r[4] && r[1];
    c = r[3] && r[0];
    return r[7] && (t || x || c);
  endfunction

  task automatic wr(input logic [7:0] v);
    @(negedge clk);
    ctl_we_i = 1'b1; ctl_wdata_i = v;
    @(negedge clk);
    ctl_we_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 ctl", ctl_rdata_o, 8'h00);
    chk("R1 req", {7'd0, irq_req_o}, 8'h00);
    chk("R1 wake", {6'd0, wake_o, wake_vector_o}, 8'h00);
  endtask

  task automatic t_write();
    wr(8'h40);
    chk("R10 spare bit", ctl_rdata_o, 8'h40);
    wr(8'h38);
    chk("R10 enables", ctl_rdata_o, 8'h38);
    wr(8'h00);
  endtask

  task automatic t_timer();
    @(negedge clk); tmr_ovf_i = 1'b1;
    @(negedge clk); tmr_ovf_i = 1'b0;
    chk("R2 set with TE=0", ctl_rdata_o, 8'h04);
    repeat (3) @(negedge clk);
    chk("R2 sticky", ctl_rdata_o, 8'h04);
    wr(8'h00);
    chk("R2 sw clear", ctl_rdata_o, 8'h00);
  endtask

  task automatic t_ext();
    edge_rise_i = 1'b1;
    @(negedge clk); ext_pin_i = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R3 not yet", ctl_rdata_o, 8'h00);
    @(negedge clk);
    chk("R3 rising", ctl_rdata_o, 8'h02);
    wr(8'h00);
    ext_pin_i = 1'b0;
    repeat (4) @(negedge clk);
    chk("R3 falling ignored when rise", ctl_rdata_o, 8'h00);
    edge_rise_i = 1'b0;
    ext_pin_i = 1'b1;
    repeat (4) @(negedge clk);
    chk("R3 rising ignored when fall", ctl_rdata_o, 8'h00);
    ext_pin_i = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R3 fall not yet", ctl_rdata_o, 8'h00);
    @(negedge clk);
    chk("R3 falling", ctl_rdata_o, 8'h02);
    wr(8'h00);
    edge_rise_i = 1'b1;
  endtask

  task automatic t_change();
    @(negedge clk); chg_pins_i = 3'b100;
    repeat (3) @(negedge clk);
    chk("R4 change with CE=0", ctl_rdata_o, 8'h01);
    port_rd_i = 1'b1;
    @(negedge clk); port_rd_i = 1'b0;
    wr(8'h00);
    repeat (2) @(negedge clk);
    chk("R4 reloaded ref", ctl_rdata_o, 8'h00);
    chg_pins_i = 3'b101;
    repeat (3) @(negedge clk);
    chk("R4 second pin", ctl_rdata_o, 8'h01);
    port_rd_i = 1'b1;
    @(negedge clk); port_rd_i = 1'b0;
    wr(8'h00);
  endtask

  task automatic t_req();
    logic [7:0] pats [6] = '{8'hA4, 8'h24, 8'h84, 8'h92, 8'h89, 8'h8E};
    foreach (pats[i]) begin
      wr(pats[i]);
      chk("R5 request", {7'd0, irq_req_o}, {7'd0, model_req(pats[i])});
    end
    wr(8'h00);
  endtask

  task automatic t_gie();
    wr(8'h80);
    @(negedge clk); irq_take_i = 1'b1;
    @(negedge clk); irq_take_i = 1'b0;
    chk("R6 take clears GE", ctl_rdata_o, 8'h00);
    retfie_i = 1'b1;
    @(negedge clk); retfie_i = 1'b0;
    chk("R6 return sets GE", ctl_rdata_o, 8'h80);
    irq_take_i = 1'b1; retfie_i = 1'b1;
    @(negedge clk); irq_take_i = 1'b0; retfie_i = 1'b0;
    chk("R6 both sets GE", ctl_rdata_o, 8'h80);
    wr(8'h00);
  endtask

  task automatic t_set_wins();
    wr(8'h04);
    @(negedge clk);
    ctl_we_i = 1'b1; ctl_wdata_i = 8'h00; tmr_ovf_i = 1'b1;
    @(negedge clk);
    ctl_we_i = 1'b0; tmr_ovf_i = 1'b0;
    chk("R7 timer set beats clear", ctl_rdata_o, 8'h04);
    wr(8'h00);
    ext_pin_i = 1'b1;
    @(negedge clk); @(negedge clk);
    ctl_we_i = 1'b1; ctl_wdata_i = 8'h00;
    @(negedge clk);
    ctl_we_i = 1'b0;
    chk("R7 ext set beats clear", ctl_rdata_o, 8'h02);
    wr(8'h00);
    ext_pin_i = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_wake();
    wr(8'h10);
    @(negedge clk); sleep_i = 1'b1;
    @(negedge clk);
    wr(8'h00);
    ext_pin_i = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 wake with XE at entry", {6'd0, wake_o, wake_vector_o}, 8'h02);
    wr(8'h82);
    chk("R9 vector with GE", {6'd0, wake_o, wake_vector_o}, 8'h03);
    sleep_i = 1'b0;
    @(negedge clk);
    chk("R8 no wake awake", {6'd0, wake_o, wake_vector_o}, 8'h00);
    wr(8'h00);
    sleep_i = 1'b1;
    repeat (2) @(negedge clk);
    wr(8'h92);
    chk("R8 XE set in sleep ignored", {6'd0, wake_o, wake_vector_o}, 8'h00);
    sleep_i = 1'b0;
    ext_pin_i = 1'b0;
    wr(8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write();
    t_timer();
    t_ext();
    t_change();
    t_req();
    t_gie();
    t_set_wins();
    t_wake();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule